// File: doc/BRIEF.md
# Shadowed Nonvolatile RAM Controller

This block fronts a byte-wide working RAM that has a nonvolatile shadow array of the same size, one shadow bit for each RAM bit. A host reaches the RAM through three active-low strobes (chip select, output enable and write enable), an 11-bit address and separate write and read data paths. A read-drive flag stands in for the tri-state bus: when the flag is low the bus is released.

Two whole-array transfers run without the host. Leaving reset counts as power-up. At that point the sequencer copies the shadow into the RAM. A rising supply-low input counts as the supply falling, and it copies the RAM into the shadow. Each transfer moves one byte per clock through a two-stage read-then-write pipeline. The host is locked out for as long as a transfer runs.

A store is held back in two cases: the RAM has not been written since power-up, or the host is holding output enable low. Both memories are synchronous behavioural models. At time zero the shadow holds a computed pattern, and it keeps its contents across reset.

Top module: `nvram_ctrl`

## Requirements
- R1: The RAM holds 2048 bytes. A read is accepted in a cycle where the block is idle, `ce_n`=0, `oe_n`=0 and `we_n`=1. In the next cycle `rdata_oe`=1 and `rdata` shows the addressed byte. In every other cycle `rdata_oe`=0 and `rdata`=0.
- R2: A write is accepted in a cycle where the block is idle, `ce_n`=0, `we_n`=0 and `oe_n`=1. The byte is stored at that clock edge.
- R3: When `ce_n`, `oe_n` and `we_n` are all 0, nothing is written and `rdata_oe` stays 0.
- R4: After reset is released, `busy` stays 1 for 2049 cycles while the whole shadow is copied into the RAM. `busy` also reads 1 while reset is held.
- R5: At time zero, shadow byte `a` holds the low 8 bits of `a` XOR 0x5A. Reset does not change the shadow.
- R6: A store starts when all of these hold in one idle cycle: `supply_low` is 1 now and was 0 in the previous cycle, `written`=1, and `oe_n`=1. From the next cycle `busy` is 1 for 2049 cycles, and the whole RAM is copied into the shadow.
- R7: A supply-low rise while `written`=0 starts no store. `busy` and `store_done` stay 0.
- R8: A supply-low rise while `oe_n`=0 starts no store, and that event is dropped.
- R9: While `busy`=1, host reads and writes are ignored: `rdata_oe` stays 0 and the RAM is unchanged.
- R10: `store_done` is a one-cycle pulse in the first idle cycle after a store. It comes within `STORE_BUDGET` cycles of the store start.
- R11: `written` is 0 after reset. It is set by the first accepted write and stays set until the next reset.
- R12: Supply-low rises that occur during a store are ignored. No second store follows when the first one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| ce_n | input | 1 | Host chip select, active low |
| oe_n | input | 1 | Host output enable, active low; also vetoes a store |
| we_n | input | 1 | Host write enable, active low |
| addr | input | 11 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data is being driven |
| supply_low | input | 1 | Digital supply-low indication |
| busy | output | 1 | A recall or store is running |
| store_done | output | 1 | One-cycle pulse at the end of a store |
| written | output | 1 | The RAM has been written since reset |

## Verification
Read data and the drive flag appear one cycle after the read is requested. A write shows up in data read back one cycle after a later read. `busy` rises in the cycle after a store trigger and falls 2049 cycles later. `store_done` then pulses for exactly one cycle. The bench changes its inputs on falling edges. Its reference model steps on rising edges using the same cycle counts, and every output is compared with the model on each falling edge, so every one of these latencies is checked to the exact cycle. The effect of a store is only visible after a later reset and recall. The bench therefore resets again and reads the whole array back.

// File: rtl/nv_pkg.sv
// Shared types for the shadowed nonvolatile RAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package nv_pkg;

    // Transfer sequencer state: two issue states and one drain state per direction.
    typedef enum logic [2:0] {
        XS_IDLE        = 3'd0,
        XS_RECALL      = 3'd1,
        XS_RECALL_TAIL = 3'd2,
        XS_STORE       = 3'd3,
        XS_STORE_TAIL  = 3'd4
    } xfer_state_t;

endpackage

// File: rtl/nv_sync_mem.sv
// Single-port synchronous behavioural memory.
// When PRESET is set, the array starts at time zero with (address ^ SEED).
// Assumes: en with we writes at the edge; en without we registers a read into q.
module nv_sync_mem #(
    parameter int              AW     = 11,
    parameter int              DW     = 8,
    parameter bit              PRESET = 1'b0,
    parameter logic [DW-1:0]   SEED   = '0
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Optional computed power-on content for the nonvolatile array.
    generate
        if (PRESET) begin : g_preset
            initial begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] = DW'(i) ^ SEED;
                end
            end
        end
    endgenerate

    // Synchronous write, or registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                q <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/nv_host_port.sv
// Host strobe decoder: turns the three active-low strobes into read and write
// requests, gates them while a transfer runs, registers the read-drive flag
// and keeps the sticky written-since-reset flag.
// Assumes: lock is high during every recall or store cycle.
module nv_host_port (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic lock,
    output logic host_rd,
    output logic host_wr,
    output logic rd_drive,
    output logic written
);
    // Legal decodes only: all three strobes low matches neither of them.
    assign host_rd = !lock && !ce_n && !oe_n &&  we_n;
    assign host_wr = !lock && !ce_n &&  oe_n && !we_n;

    // Read-drive follows an accepted read by one cycle; written is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_drive <= 1'b0;
            written  <= 1'b0;
        end else begin
            rd_drive <= host_rd;
            if (host_wr) begin
                written <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nv_xfer_seq.sv
// Whole-array transfer sequencer. After reset it recalls shadow into RAM.
// On a qualified supply-low rise it stores RAM into the shadow.
// Each direction issues a source read at ptr, then one cycle later writes
// that byte to the destination at pipe_addr.
// Assumes: the source memory's q is valid one cycle after its read enable.
module nv_xfer_seq
    import nv_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_low,
    input  logic          written,
    input  logic          oe_n,
    output logic          busy,
    output logic          storing,
    output logic          store_done,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          shd_en,
    output logic          shd_we,
    output logic [AW-1:0] shd_addr
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    xfer_state_t   st;
    logic [AW-1:0] ptr;
    logic [AW-1:0] pipe_addr;
    logic          pipe_vld;
    logic          sl_q;
    logic          done_q;
    logic          start;
    logic          rec_rd, rec_wr, sto_rd, sto_wr;

    // Store trigger: supply-low rise while idle, after a write, output enable high.
    assign start = (st == XS_IDLE) && supply_low && !sl_q && written && oe_n;

    // Advance state, address pointer and the one-deep write pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= XS_RECALL;
            ptr       <= '0;
            pipe_addr <= '0;
            pipe_vld  <= 1'b0;
            sl_q      <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            sl_q     <= supply_low;
            done_q   <= 1'b0;
            pipe_vld <= 1'b0;
            case (st)
                XS_IDLE: begin
                    if (start) begin
                        st  <= XS_STORE;
                        ptr <= '0;
                    end
                end
                XS_RECALL, XS_STORE: begin
                    pipe_vld  <= 1'b1;
                    pipe_addr <= ptr;
                    ptr       <= ptr + 1'b1;
                    if (ptr == LAST) begin
                        st <= (st == XS_RECALL) ? XS_RECALL_TAIL : XS_STORE_TAIL;
                    end
                end
                XS_RECALL_TAIL: st <= XS_IDLE;
                XS_STORE_TAIL: begin
                    st     <= XS_IDLE;
                    done_q <= 1'b1;
                end
                default: st <= XS_IDLE;
            endcase
        end
    end

    // Split the pipeline into source-read and destination-write enables per direction.
    always_comb begin
        rec_rd = (st == XS_RECALL);
        sto_rd = (st == XS_STORE);
        rec_wr = pipe_vld && ((st == XS_RECALL) || (st == XS_RECALL_TAIL));
        sto_wr = pipe_vld && ((st == XS_STORE)  || (st == XS_STORE_TAIL));
    end

    // Drive the two memory ports from the sequencer.
    always_comb begin
        ram_en   = sto_rd || rec_wr;
        ram_we   = rec_wr;
        ram_addr = rec_wr ? pipe_addr : ptr;
        shd_en   = rec_rd || sto_wr;
        shd_we   = sto_wr;
        shd_addr = sto_wr ? pipe_addr : ptr;
    end

    assign busy       = (st != XS_IDLE);
    assign storing    = (st == XS_STORE) || (st == XS_STORE_TAIL);
    assign store_done = done_q;

endmodule

// File: rtl/nvram_ctrl.sv
// Shadowed nonvolatile RAM controller, top level.
// Joins the host decoder, the transfer sequencer, the working RAM and its shadow.
// Assumes: a reset counts as power-up, and a supply-low rise counts as power loss.
module nvram_ctrl #(
    parameter int                  ADDR_W       = 11,
    parameter int                  DATA_W       = 8,
    parameter logic [DATA_W-1:0]   SHADOW_SEED  = 'h5A,
    parameter int                  STORE_BUDGET = 2100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic              supply_low,
    output logic              busy,
    output logic              store_done,
    output logic              written
);
    logic              host_rd, host_wr, rd_drive;
    logic              seq_storing;
    logic              seq_ram_en, seq_ram_we, shd_en, shd_we;
    logic [ADDR_W-1:0] seq_ram_addr, shd_addr;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_q, shd_q;

    nv_host_port u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .lock     (busy),
        .host_rd  (host_rd),
        .host_wr  (host_wr),
        .rd_drive (rd_drive),
        .written  (written)
    );

    nv_xfer_seq #(.AW(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .written    (written),
        .oe_n       (oe_n),
        .busy       (busy),
        .storing    (seq_storing),
        .store_done (store_done),
        .ram_en     (seq_ram_en),
        .ram_we     (seq_ram_we),
        .ram_addr   (seq_ram_addr),
        .shd_en     (shd_en),
        .shd_we     (shd_we),
        .shd_addr   (shd_addr)
    );

    // RAM port owner: the sequencer while busy, the host otherwise.
    always_comb begin
        ram_en    = busy ? seq_ram_en   : (host_rd || host_wr);
        ram_we    = busy ? seq_ram_we   : host_wr;
        ram_addr  = busy ? seq_ram_addr : addr;
        ram_wdata = busy ? shd_q        : wdata;
    end

    nv_sync_mem #(.AW(ADDR_W), .DW(DATA_W), .PRESET(1'b0), .SEED('0)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

    nv_sync_mem #(.AW(ADDR_W), .DW(DATA_W), .PRESET(1'b1), .SEED(SHADOW_SEED)) u_shadow (
        .clk   (clk),
        .en    (shd_en),
        .we    (shd_we),
        .addr  (shd_addr),
        .wdata (ram_q),
        .q     (shd_q)
    );

    // The bus reads zero whenever it is released.
    assign rdata_oe = rd_drive;
    assign rdata    = rd_drive ? ram_q : '0;

endmodule

// File: rtl/nvram_ctrl_chk.sv
// Temporal checks for nvram_ctrl, attached with bind.
// Assumes: storing is high for every store cycle, including the drain cycle.
module nvram_ctrl_chk #(
    parameter int STORE_BUDGET = 2100
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic supply_low,
    input logic busy,
    input logic storing,
    input logic store_done,
    input logic written,
    input logic rdata_oe
);
    int unsigned st_cnt;

    // Count the cycles of the store in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)       st_cnt <= 0;
        else if (storing) st_cnt <= st_cnt + 1;
        else              st_cnt <= 0;
    end

    // R1
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(!ce_n && !oe_n && we_n && !busy));

    // R3
    illegal_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !we_n) |=> !rdata_oe);

    // R9
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !rdata_oe);

    // R11
    written_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(written) && $past(rst_n)) |-> written);

    // R11
    written_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(written) |-> $past(!ce_n && !we_n && oe_n && !busy));

    // R6
    store_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(storing) |-> $past(written && oe_n && supply_low));

    // R10
    store_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        storing |-> (st_cnt < STORE_BUDGET));

    // R10
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |-> ($past(storing) && !busy));

endmodule

bind nvram_ctrl nvram_ctrl_chk #(.STORE_BUDGET(STORE_BUDGET)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .supply_low (supply_low),
    .busy       (busy),
    .storing    (seq_storing),
    .store_done (store_done),
    .written    (written),
    .rdata_oe   (rdata_oe)
);

// File: tb/sim_nvram_ctrl.sv
// Bench for nvram_ctrl: a behavioural reference model, compared on every falling edge.
module sim_nvram_ctrl;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    wire  [DW-1:0] rdata;
    wire           rdata_oe, busy, store_done, written;

    nvram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .supply_low(supply_low), .busy(busy), .store_done(store_done), .written(written)
    );

    int    n_chk = 0, n_err = 0, cyc = 0;
    string tag   = "R11";

    // Reference state
    logic [7:0] ram_m  [DEPTH];
    logic [7:0] shad_m [DEPTH];
    int         m_mode, m_left;
    logic       m_rdoe, m_done, m_written, m_slq;
    logic [7:0] m_rd;

    initial begin
        for (int i = 0; i < DEPTH; i++) shad_m[i] = 8'(i) ^ 8'h5A;
    end

    // Step the model on each rising edge (R4 R6 R7 R8 R9 R10 R12).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_left = DEPTH + 1;
            m_rdoe = 0; m_rd = 0; m_done = 0; m_written = 0; m_slq = 0;
            for (int i = 0; i < DEPTH; i++) ram_m[i] = shad_m[i];
        end else begin
            m_done = 0; m_rdoe = 0; m_rd = 0;
            if (m_mode != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_mode == 2) m_done = 1;
                    m_mode = 0;
                end
            end else begin
                if (!ce_n && !oe_n && we_n) begin
                    m_rdoe = 1; m_rd = ram_m[addr];
                end
                if (!ce_n && !we_n && oe_n) ram_m[addr] = wdata;
                if (supply_low && !m_slq && m_written && oe_n) begin
                    m_mode = 2; m_left = DEPTH + 1;
                    for (int i = 0; i < DEPTH; i++) shad_m[i] = ram_m[i];
                end
                if (!ce_n && !we_n && oe_n) m_written = 1;
            end
            m_slq = supply_low;
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        check("busy",       32'(busy),       32'(m_mode != 0));
        check("store_done", 32'(store_done), 32'(m_done));
        check("written",    32'(written),    32'(m_written));
        check("rdata_oe",   32'(rdata_oe),   32'(m_rdoe));
        check("rdata",      32'(rdata),      32'(m_rd));
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_err++; n_chk++;
            $display("FAIL %s watchdog: actual=%0d expected<=200000", tag, cyc);
            summary();
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); wdata = d;
        @(negedge clk); ce_n = 1; we_n = 1;
    endtask

    task automatic rd(int a);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic sweep();
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a);
            @(negedge clk);
        end
        ce_n = 1; oe_n = 1;
    endtask

    task automatic rise_supply();
        @(negedge clk); supply_low = 1;
        @(negedge clk); supply_low = 0;
    endtask

    initial begin
        tag = "R11"; repeat (3) @(negedge clk); rst_n = 1;
        tag = "R4";  wait_idle();
        tag = "R5";  sweep();
        tag = "R7";  rise_supply(); idle(20);
        tag = "R2";  wr(0, 8'h11); wr(2047, 8'hEE); wr(100, 8'h3C); wr(5, 8'h77);
        tag = "R1";  rd(0); rd(2047); rd(100); rd(5); rd(6);
        tag = "R3";
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 5; wdata = 8'h99;
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
        rd(5);
        tag = "R8";
        @(negedge clk); oe_n = 0; supply_low = 1;
        @(negedge clk); supply_low = 0; oe_n = 1;
        idle(10);
        tag = "R6";  rise_supply();
        tag = "R9";  wr(5, 8'h00); rd(5); wr(6, 8'h42);
        tag = "R12"; rise_supply(); idle(5); rise_supply();
        tag = "R10"; wait_idle(); idle(3);
        tag = "R2";  wr(5, 8'hA0); wr(3, 8'hC3); rd(5);
        tag = "R11"; @(negedge clk); rst_n = 0; idle(2); rst_n = 1;
        tag = "R4";  wait_idle();
        tag = "R6";  sweep();
        idle(4);
        summary();
    end

endmodule